// File: doc/BRIEF.md
# Framebuffer Display Controller Register File

This block is the software-visible control store of a simple framebuffer display controller. A host reaches it over a 32-bit register bus with one-cycle access. The bus carries an address, a write strobe with write data, and a read strobe; read data comes back one cycle later. The block holds seven words: the frame memory start address, a DMA control word, a DMA frame word, two display control words, a panel geometry word and a power word.

From these words the block drives a set of decoded fields to the pixel scan engine. The fields are the fetch enable, the start address, the frame width and height in pixels, and the pixel-depth code. Every write to the geometry word also raises a one-cycle resize notice, which lets the consumer rebuild its output surface.

Only the low 20 address bits take part in decoding, so the register set repeats across every 1 MiB window.

Top module: `lcd_csr_top`

## Requirements
- R1: After synchronous reset, the words read back as follows: power 0x0000000E, display control 1 0x00002000, and DMA control, DMA frame, display control 2 and geometry 0. The scan outputs show enable 0, start address 0, width 1, height 1 and pixel code 0.
- R2: Decoding uses only address bits 19:0, so 0x10000800 reaches the same word as 0x800.
- R3: The following 20-bit offsets each store a full 32-bit word and read it back: DMA frame at 0x018, DMA control at 0x01C, display control 1 at 0x800, display control 2 at 0x804, geometry at 0x810, and power at 0x83C.
- R4: A read of any other offset returns zero. A write to any other offset leaves every stored word unchanged.
- R5: The start address at offset 0x000 is write-only. A write to it updates the scan start address output, and a read of it returns zero.
- R6: Scan height equals geometry bits 10:0 plus one, and scan width equals geometry bits 31:21 plus one. Both are 12 bits wide, and both change in the cycle after the write.
- R7: The scan pixel code equals bits 7:5 of display control 2.
- R8: The scan enable equals bit 0 of DMA control.
- R9: A write to the geometry offset gives one resize pulse, high for exactly one cycle. The pulse appears one cycle after the geometry output has taken the new value, which is the second cycle after the write. Writes to other offsets give no pulse.
- R10: Read data is registered. It is valid in the cycle after the read strobe and is zero in the cycle after a cycle with no read strobe. A read and a write to the same word in one cycle return the value held before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 32 | Byte address of the access |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| scan_en | output | 1 | Frame fetch enable |
| scan_base | output | 32 | Frame memory start address |
| scan_width | output | 12 | Pixels per line |
| scan_height | output | 12 | Lines per frame |
| scan_pix_code | output | 3 | Pixel-depth code |
| resize_pulse | output | 1 | One-cycle notice of a geometry write |

## Verification
The properties take it that the host keeps the bus strobes at zero for as long as reset is held. They also take it that the strobes are known values at every clock edge, because the resize origin check looks two cycles into the past of the write strobe and address. The bench holds both strobes low through reset and drives every input half a cycle away from the sampling edge. It does not issue back-to-back geometry writes except where it checks pulse spacing, so each pulse can be tied to a single write.

// File: rtl/lcdreg_pkg.sv
package lcdreg_pkg;

    localparam int DATA_W = 32;
    localparam int DIM_W  = 12;
    localparam int FLD_W  = 11;
    localparam int PIX_W  = 3;
    localparam int OFS_W  = 20;

    localparam logic [OFS_W-1:0] OFS_BASE = 20'h00000;
    localparam logic [OFS_W-1:0] OFS_DFRM = 20'h00018;
    localparam logic [OFS_W-1:0] OFS_DCTL = 20'h0001C;
    localparam logic [OFS_W-1:0] OFS_CTL1 = 20'h00800;
    localparam logic [OFS_W-1:0] OFS_CTL2 = 20'h00804;
    localparam logic [OFS_W-1:0] OFS_GEOM = 20'h00810;
    localparam logic [OFS_W-1:0] OFS_PWR  = 20'h0083C;

    localparam logic [DATA_W-1:0] RST_PWR  = 32'h0000_000E;
    localparam logic [DATA_W-1:0] RST_CTL1 = 32'h0000_2000;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_BASE,
        SEL_DFRM,
        SEL_DCTL,
        SEL_CTL1,
        SEL_CTL2,
        SEL_GEOM,
        SEL_PWR
    } sel_e;

    typedef struct packed {
        logic [DATA_W-1:0] base;
        logic [DATA_W-1:0] dfrm;
        logic [DATA_W-1:0] dctl;
        logic [DATA_W-1:0] ctl1;
        logic [DATA_W-1:0] ctl2;
        logic [DATA_W-1:0] geom;
        logic [DATA_W-1:0] pwr;
    } regs_t;

    typedef struct packed {
        logic              en;
        logic [DATA_W-1:0] base;
        logic [DIM_W-1:0]  width;
        logic [DIM_W-1:0]  height;
        logic [PIX_W-1:0]  pix;
    } scan_t;

    function automatic sel_e decode_ofs(input logic [OFS_W-1:0] ofs);
        case (ofs)
            OFS_BASE: return SEL_BASE;
            OFS_DFRM: return SEL_DFRM;
            OFS_DCTL: return SEL_DCTL;
            OFS_CTL1: return SEL_CTL1;
            OFS_CTL2: return SEL_CTL2;
            OFS_GEOM: return SEL_GEOM;
            OFS_PWR:  return SEL_PWR;
            default:  return SEL_NONE;
        endcase
    endfunction

    function automatic logic [DIM_W-1:0] dim_plus_one(input logic [FLD_W-1:0] f);
        return {1'b0, f} + {{(DIM_W-1){1'b0}}, 1'b1};
    endfunction

    function automatic scan_t make_scan(input regs_t r);
        scan_t s;
        s.en     = r.dctl[0];
        s.base   = r.base;
        s.width  = dim_plus_one(r.geom[31:21]);
        s.height = dim_plus_one(r.geom[10:0]);
        s.pix    = r.ctl2[7:5];
        return s;
    endfunction

endpackage

// File: rtl/lcdreg_decode.sv
module lcdreg_decode
    import lcdreg_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int WIN_BITS = OFS_W
) (
    input  logic [ADDR_W-1:0] addr,
    output sel_e              sel
);
    localparam int HI_W = ADDR_W - WIN_BITS;

    logic [WIN_BITS-1:0] ofs;
    logic [HI_W-1:0]     unused_addr_hi;

    assign ofs            = addr[WIN_BITS-1:0];
    assign unused_addr_hi = addr[ADDR_W-1:WIN_BITS];
    assign sel            = decode_ofs(ofs);
endmodule

// File: rtl/lcdreg_bank.sv
module lcdreg_bank
    import lcdreg_pkg::*;
#(
    parameter int STROBE_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  sel_e              sel,
    input  logic [DATA_W-1:0] wdata,
    output regs_t             regs,
    output logic              resize
);
    logic [STROBE_STAGES-1:0] geom_pipe;

    always_ff @(posedge clk) begin
        if (rst) begin
            regs.base <= '0;
            regs.dfrm <= '0;
            regs.dctl <= '0;
            regs.ctl1 <= RST_CTL1;
            regs.ctl2 <= '0;
            regs.geom <= '0;
            regs.pwr  <= RST_PWR;
        end else if (we) begin
            case (sel)
                SEL_BASE: regs.base <= wdata;
                SEL_DFRM: regs.dfrm <= wdata;
                SEL_DCTL: regs.dctl <= wdata;
                SEL_CTL1: regs.ctl1 <= wdata;
                SEL_CTL2: regs.ctl2 <= wdata;
                SEL_GEOM: regs.geom <= wdata;
                SEL_PWR:  regs.pwr  <= wdata;
                default:  ;
            endcase
        end
    end

    generate
        for (genvar i = 0; i < STROBE_STAGES; i++) begin : g_pipe
            if (i == 0) begin : g_head
                always_ff @(posedge clk) begin
                    if (rst) geom_pipe[0] <= 1'b0;
                    else     geom_pipe[0] <= we && (sel == SEL_GEOM);
                end
            end else begin : g_tail
                always_ff @(posedge clk) begin
                    if (rst) geom_pipe[i] <= 1'b0;
                    else     geom_pipe[i] <= geom_pipe[i-1];
                end
            end
        end
    endgenerate

    assign resize = geom_pipe[STROBE_STAGES-1];
endmodule

// File: rtl/lcdreg_read.sv
module lcdreg_read
    import lcdreg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              re,
    input  sel_e              sel,
    input  regs_t             regs,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] mux;

    always_comb begin
        case (sel)
            SEL_DFRM: mux = regs.dfrm;
            SEL_DCTL: mux = regs.dctl;
            SEL_CTL1: mux = regs.ctl1;
            SEL_CTL2: mux = regs.ctl2;
            SEL_GEOM: mux = regs.geom;
            SEL_PWR:  mux = regs.pwr;
            default:  mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)     rdata <= '0;
        else if (re) rdata <= mux;
        else         rdata <= '0;
    end
endmodule

// File: rtl/lcd_csr_top.sv
module lcd_csr_top
    import lcdreg_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int WIN_BITS = OFS_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_re,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              scan_en,
    output logic [DATA_W-1:0] scan_base,
    output logic [DIM_W-1:0]  scan_width,
    output logic [DIM_W-1:0]  scan_height,
    output logic [PIX_W-1:0]  scan_pix_code,
    output logic              resize_pulse
);
    sel_e  sel;
    regs_t regs;
    scan_t scan;

    lcdreg_decode #(.ADDR_W(ADDR_W), .WIN_BITS(WIN_BITS)) u_dec (
        .addr (bus_addr),
        .sel  (sel)
    );

    lcdreg_bank #(.STROBE_STAGES(2)) u_bank (
        .clk    (clk),
        .rst    (rst),
        .we     (bus_we),
        .sel    (sel),
        .wdata  (bus_wdata),
        .regs   (regs),
        .resize (resize_pulse)
    );

    lcdreg_read u_rd (
        .clk   (clk),
        .rst   (rst),
        .re    (bus_re),
        .sel   (sel),
        .regs  (regs),
        .rdata (bus_rdata)
    );

    assign scan          = make_scan(regs);
    assign scan_en       = scan.en;
    assign scan_base     = scan.base;
    assign scan_width    = scan.width;
    assign scan_height   = scan.height;
    assign scan_pix_code = scan.pix;
endmodule

// File: rtl/lcd_csr_chk.sv
module lcd_csr_chk (
    input logic        clk,
    input logic        rst,
    input logic [31:0] bus_addr,
    input logic        bus_we,
    input logic [31:0] bus_wdata,
    input logic        bus_re,
    input logic [31:0] bus_rdata,
    input logic        scan_en,
    input logic [11:0] scan_width,
    input logic [7:0]  unused_mid,
    input logic        resize_pulse
);
    logic [19:0] ofs;
    logic        hit_geom;
    logic        hit_dctl;
    logic        hit_base;
    logic        hit_none;

    assign ofs      = bus_addr[19:0];
    assign hit_geom = (ofs == 20'h00810);
    assign hit_dctl = (ofs == 20'h0001C);
    assign hit_base = (ofs == 20'h00000);
    assign hit_none = !(ofs == 20'h00000 || ofs == 20'h00018 || ofs == 20'h0001C ||
                        ofs == 20'h00800 || ofs == 20'h00804 || ofs == 20'h00810 ||
                        ofs == 20'h0083C);

    // R9
    resize_single_chk: assert property (@(posedge clk) disable iff (rst)
        resize_pulse |=> !resize_pulse);

    // R9
    resize_origin_chk: assert property (@(posedge clk) disable iff (rst)
        resize_pulse |-> ($past(bus_we, 2) && $past(hit_geom, 2)));

    // R10
    rdata_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !bus_re |=> (bus_rdata == 32'h0));

    // R4
    unmapped_read_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_re && hit_none) |=> (bus_rdata == 32'h0));

    // R5
    base_read_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_re && hit_base) |=> (bus_rdata == 32'h0));

    // R6
    width_track_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_we && hit_geom) |=> (scan_width == {1'b0, $past(bus_wdata[31:21])} + 12'd1));

    // R8
    enable_track_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_we && hit_dctl) |=> (scan_en == $past(bus_wdata[0])));
endmodule

bind lcd_csr_top lcd_csr_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .bus_addr     (bus_addr),
    .bus_we       (bus_we),
    .bus_wdata    (bus_wdata),
    .bus_re       (bus_re),
    .bus_rdata    (bus_rdata),
    .scan_en      (scan_en),
    .scan_width   (scan_width),
    .unused_mid   (8'h00),
    .resize_pulse (resize_pulse)
);

// File: tb/lcd_csr_top_bench.sv
module lcd_csr_top_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 10;

    // {address, write data, expected read-back}
    localparam logic [95:0] VEC [NVEC] = '{
        {32'h0000_0018, 32'hA5A5_0001, 32'hA5A5_0001},
        {32'h0000_001C, 32'h0000_0001, 32'h0000_0001},
        {32'h0000_0800, 32'h1234_5678, 32'h1234_5678},
        {32'h0000_0804, 32'h0000_00E0, 32'h0000_00E0},
        {32'h0000_0810, 32'h0020_0009, 32'h0020_0009},
        {32'h0000_083C, 32'hFFFF_FFFF, 32'hFFFF_FFFF},
        {32'h0000_0000, 32'hDEAD_BEEF, 32'h0000_0000},
        {32'h0000_0004, 32'h1111_1111, 32'h0000_0000},
        {32'h1000_0800, 32'hCAFE_0000, 32'hCAFE_0000},
        {32'h0000_07FC, 32'h0000_0005, 32'h0000_0000}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic        bus_re = 1'b0;
    logic [31:0] bus_rdata;
    logic        scan_en;
    logic [31:0] scan_base;
    logic [11:0] scan_width;
    logic [11:0] scan_height;
    logic [2:0]  scan_pix_code;
    logic        resize_pulse;

    int checks = 0;
    int fails  = 0;
    logic [31:0] got;

    always #(CLK_PERIOD/2) clk = ~clk;

    lcd_csr_top u_lcd_csr_top (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_re(bus_re), .bus_rdata(bus_rdata),
        .scan_en(scan_en), .scan_base(scan_base), .scan_width(scan_width),
        .scan_height(scan_height), .scan_pix_code(scan_pix_code),
        .resize_pulse(resize_pulse)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [31:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(posedge clk); #1;
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [31:0] a, output logic [31:0] d);
        bus_addr = a; bus_re = 1'b1;
        @(posedge clk); #1;
        bus_re = 1'b0;
        d = bus_rdata;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1 reset state
        rd(32'h83C, got); chk("R1 power", got, 32'h0000_000E);
        rd(32'h800, got); chk("R1 ctl1", got, 32'h0000_2000);
        rd(32'h01C, got); chk("R1 dma ctl", got, 32'h0);
        rd(32'h018, got); chk("R1 dma frame", got, 32'h0);
        rd(32'h804, got); chk("R1 ctl2", got, 32'h0);
        rd(32'h810, got); chk("R1 geom", got, 32'h0);
        chk("R1 scan_en", {31'h0, scan_en}, 32'h0);
        chk("R1 scan_base", scan_base, 32'h0);
        chk("R1 width", {20'h0, scan_width}, 32'd1);
        chk("R1 height", {20'h0, scan_height}, 32'd1);
        chk("R1 pix", {29'h0, scan_pix_code}, 32'h0);

        // R3 R4 R5 R2 vector walk
        for (int i = 0; i < NVEC; i++) begin
            wr(VEC[i][95:64], VEC[i][63:32]);
            rd(VEC[i][95:64], got);
            chk("R3/R4/R5 vector readback", got, VEC[i][31:0]);
        end

        // R2 alias reached the plain offset
        rd(32'h0000_0800, got); chk("R2 alias", got, 32'hCAFE_0000);
        // R4 unmapped writes left stored words intact
        rd(32'h0000_0018, got); chk("R4 dfrm intact", got, 32'hA5A5_0001);
        rd(32'h0000_083C, got); chk("R4 pwr intact", got, 32'hFFFF_FFFF);
        rd(32'h0000_0804, got); chk("R4 ctl2 intact", got, 32'h0000_00E0);
        // R5 base reached scan output
        chk("R5 scan_base", scan_base, 32'hDEAD_BEEF);
        // R7 bits 7:5 = 7
        chk("R7 pix", {29'h0, scan_pix_code}, 32'd7);
        wr(32'h804, 32'h0000_0FA0);
        chk("R7 pix field", {29'h0, scan_pix_code}, 32'd5);
        // R8 enable
        chk("R8 en on", {31'h0, scan_en}, 32'd1);
        wr(32'h01C, 32'hFFFF_FFFE);
        chk("R8 en off", {31'h0, scan_en}, 32'd0);

        // R6 R9 geometry write: width field 0x7FF, height field 0x3FF
        wr(32'h810, {11'h7FF, 10'h0, 11'h3FF});
        chk("R6 width", {20'h0, scan_width}, 32'd2048);
        chk("R6 height", {20'h0, scan_height}, 32'd1024);
        chk("R9 no pulse yet", {31'h0, resize_pulse}, 32'd0);
        @(posedge clk); #1;
        chk("R9 pulse", {31'h0, resize_pulse}, 32'd1);
        @(posedge clk); #1;
        chk("R9 pulse ends", {31'h0, resize_pulse}, 32'd0);
        // R9 other offsets give no pulse
        wr(32'h800, 32'h1);
        @(posedge clk); #1;
        chk("R9 none for ctl1", {31'h0, resize_pulse}, 32'd0);

        // R10 read during write returns the old value
        bus_addr = 32'h800; bus_wdata = 32'h0BAD_F00D; bus_we = 1'b1; bus_re = 1'b1;
        @(posedge clk); #1;
        bus_we = 1'b0; bus_re = 1'b0;
        chk("R10 old value", bus_rdata, 32'h1);
        @(posedge clk); #1;
        chk("R10 idle zero", bus_rdata, 32'h0);
        rd(32'h800, got); chk("R10 new value", got, 32'h0BAD_F00D);

        // R1 reset again restores defaults
        rst = 1'b1;
        @(posedge clk); #1;
        rst = 1'b0;
        rd(32'h83C, got); chk("R1 power after reset", got, 32'h0000_000E);
        chk("R1 width after reset", {20'h0, scan_width}, 32'd1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule